// File: doc/BRIEF.md
# ADC Power-Mode Sequencer

This block sits on the host side of a serial converter that has no dedicated power pins. It moves that converter between its active, nap and sleep states using only the two lines the host already drives: the conversion-start strobe and the serial clock. The converter drops into nap after two start-strobe rising edges with no serial-clock rising edge between them. It drops into sleep after four such edges. Any serial-clock rising edge brings it back out.

The host raises one-cycle requests to convert, nap, sleep or wake. The sequencer produces the matching strobe and clock pattern. After a wake, it keeps the ready flag low for a recovery time that depends on the mode just left: short after nap, long after sleep, while the converter's reference settles. A conversion request that arrives while the converter is dozing is remembered. The sequencer wakes the converter, waits out the recovery, and then runs the conversion. In a conversion the serial clock runs for a whole frame, so the start-strobe edge count is cleared.

The serial clock period is two system-clock cycles: one cycle high, one cycle low. The start strobe is high for exactly one serial-clock period.

Top module: `pm_seq`

## Requirements
- R1: After a synchronous reset, the outputs are: ready is 1, mode is 2'b00 (active), and adc_conv and adc_sck are both 0.
- R2: A nap request while idle and active produces exactly two adc_conv pulses and no adc_sck rising edge. Afterwards mode is 2'b01 (nap) and ready is 0.
- R3: A sleep request while idle and active produces exactly four adc_conv pulses and no adc_sck edge. A sleep request while in nap produces exactly two further pulses. In both cases mode ends at 2'b10 (sleep).
- R4: Every adc_conv pulse is high for exactly 2 clock cycles. Within a burst, consecutive pulses are separated by at least CONV_LOW low cycles.
- R5: A wake request in nap or sleep produces exactly WAKE_SCK adc_sck pulses, each 1 cycle high and 1 cycle low, and no adc_conv pulse. Afterwards mode is 2'b00.
- R6: After a wake, ready rises exactly RECOV+3 clock cycles after the cycle in which the last wake adc_sck pulse falls. RECOV is NAP_RECOV when leaving nap and SLEEP_RECOV when leaving sleep.
- R7: A conversion request while idle and active produces one adc_conv pulse and FRAME_SCK adc_sck pulses, both starting in the same cycle. Mode stays 2'b00 and ready returns to 1.
- R8: A conversion request in nap or sleep first wakes the converter as in R5 and R6, then performs the conversion as in R7. In total there is 1 adc_conv pulse and WAKE_SCK+FRAME_SCK adc_sck pulses, and the block ends active and ready.
- R9: The following requests produce no edge on either line and leave mode unchanged: wake while active, nap while in nap, and nap or sleep while in sleep.
- R10: Ready is 1 only when mode is 2'b00 and no sequence is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_conv | input | 1 | Conversion request, one cycle |
| req_nap | input | 1 | Nap request, one cycle |
| req_sleep | input | 1 | Sleep request, one cycle |
| req_wake | input | 1 | Wake request, one cycle |
| adc_conv | output | 1 | Conversion-start strobe to the converter |
| adc_sck | output | 1 | Serial clock to the converter |
| mode | output | 2 | Converter state: 00 active, 01 nap, 10 sleep |
| ready | output | 1 | Converter active, settled and idle |

## Verification
Two situations are the hardest to reach from the ports. The first is a sleep that is reached in two steps, where the four strobe edges are split across a nap request and a later sleep request. The second is a conversion request that arrives during sleep, so a remembered conversion has to follow the long recovery. The bench drives every ordered pair of the four requests from a fresh reset, which reaches both situations. A pin-level model of the converter counts strobe edges between clock edges to confirm the mode that results. A cycle stamp on the last wake clock fall and on the rise of ready measures the recovery gap.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [1:0] {
    PM_ACTIVE = 2'b00,
    PM_NAP    = 2'b01,
    PM_SLEEP  = 2'b10
  } pm_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ENTER,
    ST_DOZE,
    ST_WAKE,
    ST_SETTLE,
    ST_CONVERT
  } pm_state_e;
endpackage

// File: rtl/pm_pulse_gen.sv
module pm_pulse_gen #(
  parameter int HI = 1,
  parameter int LO = 1,
  parameter int NW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [NW-1:0] num,
  output logic          line,
  output logic          busy
);
  localparam int PW = $clog2(HI + LO + 1);

  logic [PW-1:0] phase;
  logic [NW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      line  <= 1'b0;
      busy  <= 1'b0;
      phase <= '0;
      left  <= '0;
    end else if (!busy) begin
      if (start && num != '0) begin
        busy  <= 1'b1;
        line  <= 1'b1;
        phase <= PW'(HI - 1);
        left  <= num - 1'b1;
      end
    end else if (phase != '0) begin
      phase <= phase - 1'b1;
    end else if (line) begin
      line  <= 1'b0;
      phase <= PW'(LO - 1);
    end else if (left != '0) begin
      line  <= 1'b1;
      phase <= PW'(HI - 1);
      left  <= left - 1'b1;
    end else begin
      busy <= 1'b0;
    end
  end

  assert_line_in_burst_R4: assert property (@(posedge clk) disable iff (rst)
    line |-> busy);

  generate
    if (LO >= 2) begin : g_low_hold
      assert_low_hold_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(line) |=> !line);
    end
  endgenerate
endmodule

// File: rtl/pm_settle_timer.sv
module pm_settle_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] val,
  output logic          done
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  assert_count_down_R6: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/pm_seq.sv
module pm_seq
  import pm_pkg::*;
#(
  parameter int FRAME_SCK   = 96,
  parameter int WAKE_SCK    = 1,
  parameter int CONV_LOW    = 2,
  parameter int NAP_RECOV   = 1,
  parameter int SLEEP_RECOV = 200000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_conv,
  input  logic       req_nap,
  input  logic       req_sleep,
  input  logic       req_wake,
  output logic       adc_conv,
  output logic       adc_sck,
  output logic [1:0] mode,
  output logic       ready
);
  localparam int SCK_MAX = (FRAME_SCK > WAKE_SCK) ? FRAME_SCK : WAKE_SCK;
  localparam int SNW     = $clog2(SCK_MAX + 1);
  localparam int CNW     = 3;
  localparam int T_MAX   = (SLEEP_RECOV > NAP_RECOV) ? SLEEP_RECOV : NAP_RECOV;
  localparam int TW      = $clog2(T_MAX + 1);

  pm_state_e st, st_n;
  pm_mode_e  mode_q, mode_n, tgt, tgt_n;
  logic      ready_q, rdy_n, pend, pend_n;

  logic           conv_go, conv_busy, sck_go, sck_busy, tmr_go, tmr_done;
  logic [CNW-1:0] conv_cnt;
  logic [SNW-1:0] sck_cnt;
  logic [TW-1:0]  tmr_val;

  pm_pulse_gen #(.HI(2), .LO(CONV_LOW), .NW(CNW)) u_conv (
    .clk(clk), .rst(rst), .start(conv_go), .num(conv_cnt),
    .line(adc_conv), .busy(conv_busy));

  pm_pulse_gen #(.HI(1), .LO(1), .NW(SNW)) u_sck (
    .clk(clk), .rst(rst), .start(sck_go), .num(sck_cnt),
    .line(adc_sck), .busy(sck_busy));

  pm_settle_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_go), .val(tmr_val), .done(tmr_done));

  always_comb begin
    st_n     = st;
    mode_n   = mode_q;
    tgt_n    = tgt;
    rdy_n    = ready_q;
    pend_n   = pend;
    conv_go  = 1'b0;
    conv_cnt = '0;
    sck_go   = 1'b0;
    sck_cnt  = '0;
    tmr_go   = 1'b0;
    tmr_val  = '0;
    unique case (st)
      ST_IDLE: begin
        if (pend || req_conv) begin
          conv_go  = 1'b1;
          conv_cnt = CNW'(1);
          sck_go   = 1'b1;
          sck_cnt  = SNW'(FRAME_SCK);
          pend_n   = 1'b0;
          rdy_n    = 1'b0;
          st_n     = ST_CONVERT;
        end else if (req_sleep || req_nap) begin
          conv_go  = 1'b1;
          conv_cnt = req_sleep ? CNW'(4) : CNW'(2);
          tgt_n    = req_sleep ? PM_SLEEP : PM_NAP;
          rdy_n    = 1'b0;
          st_n     = ST_ENTER;
        end
      end
      ST_ENTER: begin
        if (!conv_busy) begin
          mode_n = tgt;
          st_n   = ST_DOZE;
        end
      end
      ST_DOZE: begin
        if (req_conv || req_wake) begin
          sck_go  = 1'b1;
          sck_cnt = SNW'(WAKE_SCK);
          pend_n  = req_conv;
          st_n    = ST_WAKE;
        end else if (req_sleep && mode_q == PM_NAP) begin
          conv_go  = 1'b1;
          conv_cnt = CNW'(2);
          tgt_n    = PM_SLEEP;
          st_n     = ST_ENTER;
        end
      end
      ST_WAKE: begin
        if (!sck_busy) begin
          tmr_go  = 1'b1;
          tmr_val = (mode_q == PM_SLEEP) ? TW'(SLEEP_RECOV) : TW'(NAP_RECOV);
          mode_n  = PM_ACTIVE;
          st_n    = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        if (tmr_done) begin
          rdy_n = 1'b1;
          st_n  = ST_IDLE;
        end
      end
      ST_CONVERT: begin
        if (!conv_busy && !sck_busy) begin
          rdy_n = 1'b1;
          st_n  = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      mode_q  <= PM_ACTIVE;
      tgt     <= PM_ACTIVE;
      ready_q <= 1'b1;
      pend    <= 1'b0;
    end else begin
      st      <= st_n;
      mode_q  <= mode_n;
      tgt     <= tgt_n;
      ready_q <= rdy_n;
      pend    <= pend_n;
    end
  end

  assign mode  = mode_q;
  assign ready = ready_q;

  assert_ready_active_R10: assert property (@(posedge clk) disable iff (rst)
    ready |-> (mode == PM_ACTIVE));

  assert_settle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SETTLE) |-> !ready);

  assert_quiet_sck_R2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ENTER) |-> !adc_sck);

  assert_conv_width_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(adc_conv) |=> adc_conv ##1 !adc_conv);

  assert_wake_no_conv_R5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAKE) |-> !adc_conv);
endmodule

// File: tb/sim_pm_seq.sv
module sim_pm_seq;
  localparam int F  = 6;
  localparam int W  = 2;
  localparam int CL = 3;
  localparam int NR = 1;
  localparam int SR = 20;

  logic clk = 1'b0, rst = 1'b1;
  logic req_conv = 1'b0, req_nap = 1'b0, req_sleep = 1'b0, req_wake = 1'b0;
  logic adc_conv, adc_sck, ready;
  logic [1:0] mode;

  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  pm_seq #(.FRAME_SCK(F), .WAKE_SCK(W), .CONV_LOW(CL),
           .NAP_RECOV(NR), .SLEEP_RECOV(SR)) u0 (
    .clk(clk), .rst(rst), .req_conv(req_conv), .req_nap(req_nap),
    .req_sleep(req_sleep), .req_wake(req_wake), .adc_conv(adc_conv),
    .adc_sck(adc_sck), .mode(mode), .ready(ready));

  // Pin-level monitor and converter model, sampled 2 ns after each rising edge.
  int cyc = 0, n_conv = 0, n_sck = 0, bad_w = 0;
  int hi_run = 0, lo_run = 0, last_fall = 0, gap_val = 0;
  int edges = 0, model_mode = 0;
  bit seen_pulse = 0, gap_valid = 0;
  logic p_conv = 1'b0, p_sck = 1'b0, p_rdy = 1'b0;

  always @(posedge clk) begin
    #2;
    cyc++;
    if (rst) begin
      edges = 0; model_mode = 0; seen_pulse = 0;
    end else begin
      if (adc_conv && !p_conv) begin
        n_conv++;
        edges++;
        if (seen_pulse && lo_run < CL) bad_w++;
        hi_run = 1;
      end else if (adc_conv) begin
        hi_run++;
      end else if (p_conv) begin
        if (hi_run != 2) bad_w++;
        lo_run = 1;
        seen_pulse = 1;
      end else begin
        lo_run++;
      end
      if (adc_sck && !p_sck) begin
        n_sck++;
        edges = 0;
        model_mode = 0;
      end
      if (!adc_sck && p_sck) last_fall = cyc;
      if (edges >= 4) model_mode = 2;
      else if (edges >= 2 && model_mode == 0) model_mode = 1;
      if (ready && !p_rdy && !gap_valid) begin
        gap_val = cyc - last_fall;
        gap_valid = 1;
      end
    end
    p_conv = adc_conv; p_sck = adc_sck; p_rdy = ready;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  int em = 0;

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(ready == 1'b1, "R1 ready", int'(ready), 1);
    chk(mode == 2'b00, "R1 mode", int'(mode), 0);
    chk(adc_conv == 1'b0 && adc_sck == 1'b0, "R1 lines",
        int'({adc_conv, adc_sck}), 0);
    em = 0;
  endtask

  // op: 0 conversion, 1 nap, 2 sleep, 3 wake
  task automatic do_op(input int op);
    int c0, s0, ec, es, emode, egap, bw0;
    string tag;
    c0 = n_conv; s0 = n_sck; bw0 = bad_w;
    gap_valid = 0;
    ec = 0; es = 0; emode = em; egap = -1; tag = "R9";
    case (em)
      0: case (op)
           0: begin ec = 1; es = F; tag = "R7"; end
           1: begin ec = 2; emode = 1; tag = "R2"; end
           2: begin ec = 4; emode = 2; tag = "R3"; end
           default: ;
         endcase
      default: case (op)
           0: begin ec = 1; es = W + F; emode = 0; tag = "R8";
                    egap = ((em == 2) ? SR : NR) + 3; end
           3: begin es = W; emode = 0; tag = "R5";
                    egap = ((em == 2) ? SR : NR) + 3; end
           2: if (em == 1) begin ec = 2; emode = 2; tag = "R3"; end
           default: ;
         endcase
    endcase
    @(negedge clk);
    req_conv  = (op == 0);
    req_nap   = (op == 1);
    req_sleep = (op == 2);
    req_wake  = (op == 3);
    @(negedge clk);
    req_conv = 1'b0; req_nap = 1'b0; req_sleep = 1'b0; req_wake = 1'b0;
    repeat (80) @(negedge clk);
    chk(int'(mode) == emode, {tag, " mode"}, int'(mode), emode);
    chk(n_conv - c0 == ec, {tag, " conv pulses"}, n_conv - c0, ec);
    chk(n_sck - s0 == es, {tag, " sck pulses"}, n_sck - s0, es);
    chk(model_mode == emode, {tag, " converter state at pins"}, model_mode, emode);
    chk(int'(ready) == int'(emode == 0), "R10 ready", int'(ready), int'(emode == 0));
    chk(bad_w == bw0, "R4 conv pulse shape", bad_w - bw0, 0);
    if (egap >= 0)
      chk(gap_valid && gap_val == egap, "R6 recovery gap", gap_val, egap);
    em = emode;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        do_reset();
        do_op(a);
        do_op(b);
      end
    end
    // reach sleep in two steps, then wake with a remembered conversion
    do_reset();
    do_op(1);
    do_op(2);
    do_op(0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog R1-wide: actual %0d expected %0d", 100000, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule